// File: doc/BRIEF.md
# SPI NAND Page Operation Sequencer

This block carries out whole page reads, page programs and block erases against a serial NAND flash device. It does not drive the serial pins. Instead it hands a series of frame descriptors to a separate frame engine. Each descriptor gives an opcode, up to three address bytes, a transmit count and a receive count. Between the steps of an operation the block reads the device status register, and keeps reading it until the device reports that it is idle. It then reduces the final status byte to a single result code.

A client starts an operation with a one-cycle request that carries:
- the kind of operation;
- a row address (a page, or any page inside the block to erase);
- a column offset;
- a byte count.

Program data is pulled from the client one byte at a time, whenever the frame engine asks for a byte. Read data is passed to the client in the same cycle the engine delivers it. Only one operation runs at a time. The block gives up polling after a cycle budget, and that budget is longer for an erase than for a read or a program.

The frame engine behaves as follows:
- It accepts a descriptor with `fr_valid`/`fr_ready`.
- After accepting, it moves bytes on the `rx_*` and `tx_*` signals.
- Later, in a cycle after its last data byte, it pulses `fr_done`.

A descriptor with three address bytes sends `fr_addr[23:16]` first. A descriptor with two address bytes sends `fr_addr[15:0]`, and one with a single address byte sends `fr_addr[7:0]`.

Top module: `nand_opseq`

## Requirements
- R1: A request is accepted only when `busy` is low and `req_op` is 0 (read), 1 (program) or 2 (erase). `busy` is high from the cycle after acceptance through the `res_valid` cycle and low the cycle after that. Op code 3, and any request made while busy, is ignored: no frame is issued and no result is produced.
- R2: A read issues opcode 0x13 with three address bytes (the row, zero-extended). After the status polls it issues opcode 0x03 with three address bytes {column high, column low, 0x00} and a receive count equal to the transfer length.
- R3: Each status poll is opcode 0x0F with one address byte 0xC0, receive count 1 and transmit count 0. Polls repeat while status bit 0 (busy) is set.
- R4: A program issues, in order: opcode 0x06 with no address; opcode 0x02 with two address bytes (the column) and a transmit count equal to the transfer length, its bytes taken from `wr_data` in order; opcode 0x10 with the row in three address bytes; then status polls.
- R5: An erase issues opcode 0x06, then opcode 0xD8 with the row rounded down to a multiple of PAGES_PER_BLOCK (64), then status polls.
- R6: From the first status with bit 0 clear, a program reports code 1 if bit 3 is set and code 0 otherwise, and an erase reports code 2 if bit 2 is set and code 0 otherwise. Any other status bits are ignored, and so are bits seen while busy.
- R7: A read decodes status bits [5:4] of the ready status as follows: 00 gives code 0, 01 gives code 3 (corrected), and both 10 and 11 give code 4 (uncorrectable). Bits 2 and 3 are ignored on a read.
- R8: An uncorrectable read still issues the cache read and delivers every byte before it reports code 4.
- R9: The poll timer starts when the operation frame completes. If a poll returns busy once TMO_RDPG cycles (read, program) or TMO_ERASE cycles (erase) have elapsed, the block reports code 5 and issues no further frame.
- R10: The transfer length is the smaller of the requested length and PAGE_BYTES (2112) minus the column. It is 0 when the column is PAGE_BYTES or beyond.
- R11: Bytes received during the cache read appear on `rd_valid`/`rd_data` in the same cycle. Status bytes never appear there.
- R12: A descriptor stays valid, with stable fields, until `fr_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| req_row | input | ROW_W | Page or block row address |
| req_col | input | COL_W | Column offset in the page |
| req_len | input | LEN_W | Requested byte count |
| busy | output | 1 | An operation is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 3 | 0 ok, 1 program fail, 2 erase fail, 3 ECC corrected, 4 ECC uncorrectable, 5 timeout |
| fr_valid | output | 1 | Descriptor valid |
| fr_ready | input | 1 | Descriptor accepted by the frame engine |
| fr_opcode | output | 8 | Command opcode |
| fr_naddr | output | 2 | Number of address bytes (0 to 3) |
| fr_addr | output | 24 | Address bytes |
| fr_ntx | output | LEN_W | Bytes to transmit after the address |
| fr_nrx | output | LEN_W | Bytes to receive after the address |
| fr_done | input | 1 | Frame finished |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_req | input | 1 | Frame engine wants a transmit byte |
| tx_data | output | 8 | Transmit byte |
| wr_data | input | 8 | Program byte offered by the client |
| wr_take | output | 1 | Client byte consumed this cycle |
| rd_valid | output | 1 | Read data strobe to the client |
| rd_data | output | 8 | Read data byte |

## Verification
The in-RTL assertions check the cycle-level contracts on every cycle:
- the busy window around accept and result;
- descriptors held stable until accepted;
- descriptor, read-data and write-data activity never overlapping;
- the poll timer never going backward on its own;
- fail codes never appearing for the wrong operation.

Only the directed scenarios can show the rest:
- the exact frame order and address bytes of each flow;
- row rounding for an erase;
- length clamping in the spare area;
- the decode of each status pattern;
- that an uncorrectable read still delivers its data;
- that the erase budget outlasts a busy period that times out a read.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    RES_OK         = 3'd0,
    RES_PROG_FAIL  = 3'd1,
    RES_ERASE_FAIL = 3'd2,
    RES_ECC_FIXED  = 3'd3,
    RES_ECC_BAD    = 3'd4,
    RES_TIMEOUT    = 3'd5
  } res_e;

  typedef enum logic [2:0] {
    STP_WREN,
    STP_LOAD,
    STP_EXEC,
    STP_FETCH,
    STP_ERASE,
    STP_POLL,
    STP_CREAD
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ISSUE,
    PH_WAIT,
    PH_DONE
  } phase_e;

  localparam logic [7:0] OPC_WREN    = 8'h06;
  localparam logic [7:0] OPC_LOAD    = 8'h02;
  localparam logic [7:0] OPC_EXEC    = 8'h10;
  localparam logic [7:0] OPC_FETCH   = 8'h13;
  localparam logic [7:0] OPC_ERASE   = 8'hD8;
  localparam logic [7:0] OPC_GETF    = 8'h0F;
  localparam logic [7:0] OPC_CREAD   = 8'h03;
  localparam logic [7:0] FEAT_STATUS = 8'hC0;

  // Transfer length: the requested count, limited to what is left in the page.
  function automatic int unsigned clamp_len(input int unsigned col,
                                            input int unsigned len,
                                            input int unsigned page);
    if (col >= page) return 0;
    if (len > page - col) return page - col;
    return len;
  endfunction

  // First row of the block that holds the given row.
  function automatic logic [23:0] block_base(input logic [23:0] row,
                                             input int unsigned ppb);
    return row - (row % 24'(ppb));
  endfunction

  // Reduction of the two-bit ECC field; the reserved value counts as uncorrectable.
  function automatic res_e ecc_result(input logic [1:0] f);
    case (f)
      2'b00:   return RES_OK;
      2'b01:   return RES_ECC_FIXED;
      default: return RES_ECC_BAD;
    endcase
  endfunction

  function automatic step_e first_step(input op_e op);
    return (op == OP_READ) ? STP_FETCH : STP_WREN;
  endfunction

endpackage

// File: rtl/nseq_frame_build.sv
module nseq_frame_build
  import nseq_pkg::*;
#(
  parameter int unsigned ROW_W           = 16,
  parameter int unsigned COL_W           = 12,
  parameter int unsigned LEN_W           = 12,
  parameter int unsigned PAGES_PER_BLOCK = 64
) (
  input  step_e             step,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  input  logic [LEN_W-1:0]  len,
  output logic [7:0]        opcode,
  output logic [1:0]        naddr,
  output logic [23:0]       addr,
  output logic [LEN_W-1:0]  ntx,
  output logic [LEN_W-1:0]  nrx
);

  logic [23:0] row24;
  logic [15:0] col16;

  assign row24 = 24'(row);
  assign col16 = 16'(col);

  always_comb begin
    opcode = OPC_WREN;
    naddr  = 2'd0;
    addr   = 24'h0;
    ntx    = '0;
    nrx    = '0;
    case (step)
      STP_WREN: begin
        opcode = OPC_WREN;
      end
      STP_LOAD: begin
        opcode = OPC_LOAD;
        naddr  = 2'd2;
        addr   = {8'h00, col16};
        ntx    = len;
      end
      STP_EXEC: begin
        opcode = OPC_EXEC;
        naddr  = 2'd3;
        addr   = row24;
      end
      STP_FETCH: begin
        opcode = OPC_FETCH;
        naddr  = 2'd3;
        addr   = row24;
      end
      STP_ERASE: begin
        opcode = OPC_ERASE;
        naddr  = 2'd3;
        addr   = block_base(row24, PAGES_PER_BLOCK);
      end
      STP_POLL: begin
        opcode = OPC_GETF;
        naddr  = 2'd1;
        addr   = {16'h0000, FEAT_STATUS};
        nrx    = LEN_W'(1);
      end
      STP_CREAD: begin
        opcode = OPC_CREAD;
        naddr  = 2'd3;
        addr   = {col16, 8'h00};
        nrx    = len;
      end
      default: begin
        opcode = OPC_WREN;
      end
    endcase
  end

endmodule

// File: rtl/nseq_status_eval.sv
module nseq_status_eval
  import nseq_pkg::*;
(
  input  op_e        op,
  input  logic       st_busy,
  input  logic       st_efail,
  input  logic       st_pfail,
  input  logic [1:0] st_ecc,
  output logic       dev_busy,
  output res_e       code
);

  assign dev_busy = st_busy;

  always_comb begin
    case (op)
      OP_PROG:  code = st_pfail ? RES_PROG_FAIL  : RES_OK;
      OP_ERASE: code = st_efail ? RES_ERASE_FAIL : RES_OK;
      default:  code = ecc_result(st_ecc);
    endcase
  end

endmodule

// File: rtl/nseq_poll_timer.sv
module nseq_poll_timer #(
  parameter int unsigned TMO_RDPG  = 2000000,
  parameter int unsigned TMO_ERASE = 40000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic long_sel,
  output logic expired
);

  localparam int unsigned TMO_MAX = (TMO_ERASE > TMO_RDPG) ? TMO_ERASE : TMO_RDPG;
  localparam int unsigned CW      = $clog2(TMO_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit   = long_sel ? CW'(TMO_ERASE) : CW'(TMO_RDPG);
  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clear)           cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end

  // R9: a cleared timer starts below every non-zero limit
  a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !expired);

  // R9: once expired during polling, the timer stays expired until cleared
  a_r9_expiry_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && expired && !clear) |=> expired);

endmodule

// File: rtl/nand_opseq.sv
module nand_opseq
  import nseq_pkg::*;
#(
  parameter int unsigned ROW_W           = 16,
  parameter int unsigned COL_W           = 12,
  parameter int unsigned LEN_W           = 12,
  parameter int unsigned PAGE_BYTES      = 2112,
  parameter int unsigned PAGES_PER_BLOCK = 64,
  parameter int unsigned TMO_RDPG        = 2000000,
  parameter int unsigned TMO_ERASE       = 40000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              res_valid,
  output logic [2:0]        res_code,
  output logic              fr_valid,
  input  logic              fr_ready,
  output logic [7:0]        fr_opcode,
  output logic [1:0]        fr_naddr,
  output logic [23:0]       fr_addr,
  output logic [LEN_W-1:0]  fr_ntx,
  output logic [LEN_W-1:0]  fr_nrx,
  input  logic              fr_done,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              tx_req,
  output logic [7:0]        tx_data,
  input  logic [7:0]        wr_data,
  output logic              wr_take,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  phase_e           phase_q;
  step_e            step_q;
  op_e              op_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] len_q;
  logic [4:0]       stat_q;   // {ecc[1:0], pfail, efail, busy}
  res_e             code_q;

  // Named internal events
  logic req_fire;
  logic frame_end;
  logic stat_take;
  logic op_frame_end;
  logic tmo_run;
  logic tmo_expired;
  logic dev_busy;
  res_e eval_code;
  logic [LEN_W-1:0] len_eff;

  assign req_fire     = (phase_q == PH_IDLE) && req_valid && (req_op != OP_NONE);
  assign frame_end    = (phase_q == PH_WAIT) && fr_done;
  assign stat_take    = (phase_q == PH_WAIT) && (step_q == STP_POLL) && rx_valid;
  assign op_frame_end = frame_end &&
                        ((step_q == STP_EXEC) || (step_q == STP_FETCH) || (step_q == STP_ERASE));
  assign tmo_run      = (phase_q != PH_IDLE) && (step_q == STP_POLL);
  assign len_eff      = LEN_W'(clamp_len(32'(req_col), 32'(req_len), PAGE_BYTES));

  nseq_frame_build #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) u_build (
    .step(step_q), .row(row_q), .col(col_q), .len(len_q),
    .opcode(fr_opcode), .naddr(fr_naddr), .addr(fr_addr), .ntx(fr_ntx), .nrx(fr_nrx)
  );

  nseq_status_eval u_eval (
    .op(op_q), .st_busy(stat_q[0]), .st_efail(stat_q[1]), .st_pfail(stat_q[2]),
    .st_ecc(stat_q[4:3]), .dev_busy(dev_busy), .code(eval_code)
  );

  nseq_poll_timer #(
    .TMO_RDPG(TMO_RDPG), .TMO_ERASE(TMO_ERASE)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(op_frame_end), .run(tmo_run),
    .long_sel(op_q == OP_ERASE), .expired(tmo_expired)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= STP_WREN;
      op_q    <= OP_READ;
      row_q   <= '0;
      col_q   <= '0;
      len_q   <= '0;
      stat_q  <= '0;
      code_q  <= RES_OK;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (req_fire) begin
            op_q    <= op_e'(req_op);
            row_q   <= req_row;
            col_q   <= req_col;
            len_q   <= len_eff;
            step_q  <= first_step(op_e'(req_op));
            phase_q <= PH_ISSUE;
          end
        end
        PH_ISSUE: begin
          if (fr_ready) phase_q <= PH_WAIT;
        end
        PH_WAIT: begin
          if (stat_take) stat_q <= {rx_data[5:2], rx_data[0]};
          if (fr_done) begin
            case (step_q)
              STP_WREN: begin
                step_q  <= (op_q == OP_ERASE) ? STP_ERASE : STP_LOAD;
                phase_q <= PH_ISSUE;
              end
              STP_LOAD: begin
                step_q  <= STP_EXEC;
                phase_q <= PH_ISSUE;
              end
              STP_EXEC, STP_FETCH, STP_ERASE: begin
                step_q  <= STP_POLL;
                phase_q <= PH_ISSUE;
              end
              STP_POLL: begin
                if (dev_busy) begin
                  if (tmo_expired) begin
                    code_q  <= RES_TIMEOUT;
                    phase_q <= PH_DONE;
                  end else begin
                    phase_q <= PH_ISSUE;
                  end
                end else if (op_q == OP_READ) begin
                  code_q  <= eval_code;
                  step_q  <= STP_CREAD;
                  phase_q <= PH_ISSUE;
                end else begin
                  code_q  <= eval_code;
                  phase_q <= PH_DONE;
                end
              end
              default: phase_q <= PH_DONE;
            endcase
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy      = (phase_q != PH_IDLE);
  assign res_valid = (phase_q == PH_DONE);
  assign res_code  = code_q;
  assign fr_valid  = (phase_q == PH_ISSUE);
  assign tx_data   = wr_data;
  assign wr_take   = tx_req && (phase_q == PH_WAIT) && (step_q == STP_LOAD);
  assign rd_valid  = rx_valid && (phase_q == PH_WAIT) && (step_q == STP_CREAD);
  assign rd_data   = rx_data;

  // R1: acceptance opens the busy window with no result yet
  a_r1_busy_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (busy && !res_valid));

  // R1: the result cycle is the last busy cycle
  a_r1_release_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!busy && !res_valid));

  // R12: a pending descriptor is held with stable fields
  a_r12_descriptor_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && !fr_ready) |=> (fr_valid && $stable(fr_opcode) && $stable(fr_addr)
                                 && $stable(fr_nrx) && $stable(fr_ntx)));

  // R11: descriptor, read data and write data never overlap
  a_r11_paths_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fr_valid, rd_valid, wr_take}));

  // R7: a read never reports a program or erase failure
  a_r7_read_no_fail_code: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_q == OP_READ) |-> (res_code != RES_PROG_FAIL && res_code != RES_ERASE_FAIL));

  // R6: failure codes belong to their own operation
  a_r6_fail_matches_op: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_code == RES_PROG_FAIL || res_code == RES_ERASE_FAIL)) |->
      (res_code == RES_PROG_FAIL ? op_q == OP_PROG : op_q == OP_ERASE));

  // R10: no transfer count exceeds the page
  a_r10_counts_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid |-> (32'(fr_nrx) <= PAGE_BYTES && 32'(fr_ntx) <= PAGE_BYTES));

endmodule

// File: tb/nand_opseq_test.sv
module nand_opseq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_row = '0;
  logic [11:0] req_col = '0;
  logic [11:0] req_len = '0;
  logic        busy, res_valid;
  logic [2:0]  res_code;
  logic        fr_valid;
  logic        fr_ready = 1'b0;
  logic [7:0]  fr_opcode;
  logic [1:0]  fr_naddr;
  logic [23:0] fr_addr;
  logic [11:0] fr_ntx, fr_nrx;
  logic        fr_done = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_req = 1'b0;
  logic [7:0]  tx_data;
  logic [7:0]  wr_data;
  logic        wr_take, rd_valid;
  logic [7:0]  rd_data;

  always #4 clk = ~clk;   // 125 MHz

  nand_opseq #(.TMO_RDPG(40), .TMO_ERASE(400)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .busy(busy), .res_valid(res_valid), .res_code(res_code),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_opcode(fr_opcode),
    .fr_naddr(fr_naddr), .fr_addr(fr_addr), .fr_ntx(fr_ntx), .fr_nrx(fr_nrx),
    .fr_done(fr_done), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_req(tx_req), .tx_data(tx_data), .wr_data(wr_data), .wr_take(wr_take),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_err = 0;

  // Frame log and data capture
  logic [7:0]  lg_op [0:63];
  logic [1:0]  lg_na [0:63];
  logic [23:0] lg_ad [0:63];
  int          lg_ntx [0:63];
  int          lg_nrx [0:63];
  int          lg_n = 0;
  logic [7:0]  rdbuf [0:255];
  int          rd_n = 0;
  int          rd_leak = 0;
  logic [7:0]  wbuf [0:63];
  logic [7:0]  txbuf [0:63];
  int          tx_n = 0;
  int          widx = 0;

  // Device model
  int          dev_busy = 0;
  int          busy_left = 0;
  logic [7:0]  dev_status = 8'h00;

  assign wr_data = wbuf[widx[5:0]];

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic serve_frame();
    logic [7:0]  opc;
    logic [23:0] ad;
    int          ntx, nrx;
    opc = fr_opcode; ad = fr_addr; ntx = int'(fr_ntx); nrx = int'(fr_nrx);
    if (lg_n < 64) begin
      lg_op[lg_n] = opc; lg_na[lg_n] = fr_naddr; lg_ad[lg_n] = ad;
      lg_ntx[lg_n] = ntx; lg_nrx[lg_n] = nrx;
    end
    lg_n++;
    if (opc == 8'h13 || opc == 8'h10 || opc == 8'hD8) busy_left = dev_busy;
    fr_ready = 1'b1;
    @(negedge clk);
    fr_ready = 1'b0;
    if (opc == 8'h0F) begin
      rx_valid = 1'b1;
      if (busy_left > 0) begin
        rx_data = 8'h3D;
        busy_left--;
      end else begin
        rx_data = dev_status;
      end
      #1;
      if (rd_valid) rd_leak++;
      @(negedge clk);
      rx_valid = 1'b0;
    end else begin
      for (int i = 0; i < nrx; i++) begin
        rx_valid = 1'b1;
        rx_data  = 8'(int'(ad[23:8]) + i);
        #1;
        if (rd_valid) begin
          if (rd_n < 256) rdbuf[rd_n] = rd_data;
          rd_n++;
        end
        @(negedge clk);
      end
      rx_valid = 1'b0;
      for (int i = 0; i < ntx; i++) begin
        tx_req = 1'b1;
        #1;
        if (wr_take) begin
          if (tx_n < 64) txbuf[tx_n] = tx_data;
          tx_n++;
          widx++;
        end
        @(negedge clk);
      end
      tx_req = 1'b0;
    end
    fr_done = 1'b1;
    @(negedge clk);
    fr_done = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && fr_valid) serve_frame();
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  task automatic clear_logs(input int busy_polls, input logic [7:0] st);
    lg_n = 0; rd_n = 0; tx_n = 0; widx = 0;
    dev_busy = busy_polls; dev_status = st; busy_left = 0;
  endtask

  task automatic start_op(input logic [1:0] op, input logic [15:0] row,
                          input logic [11:0] col, input logic [11:0] len);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_row = row; req_col = col; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R1", "busy after accept", int'(busy), 1);
  endtask

  task automatic wait_result(output int code);
    int n;
    code = -1;
    n = 0;
    while (n < 5000) begin
      @(negedge clk);
      if (res_valid) begin
        code = int'(res_code);
        break;
      end
      n++;
    end
    @(negedge clk);
    chk_eq("R1", "busy after result", int'(busy), 0);
  endtask

  task automatic run_op(input logic [1:0] op, input logic [15:0] row, input logic [11:0] col,
                        input logic [11:0] len, output int code);
    start_op(op, row, col, len);
    wait_result(code);
  endtask

  task automatic t_reset();
    chk_eq("R1", "reset busy", int'(busy), 0);
    chk_eq("R1", "reset res_valid", int'(res_valid), 0);
    chk_eq("R12", "reset fr_valid", int'(fr_valid), 0);
  endtask

  task automatic t_read_ok();
    int code;
    clear_logs(2, 8'h00);
    run_op(2'd0, 16'h0123, 12'h010, 12'd8, code);
    chk_eq("R7", "read ok code", code, 0);
    chk_eq("R2", "read frame count", lg_n, 5);
    chk_eq("R2", "fetch opcode", int'(lg_op[0]), 'h13);
    chk_eq("R2", "fetch naddr", int'(lg_na[0]), 3);
    chk_eq("R2", "fetch addr", int'(lg_ad[0]), 'h000123);
    chk_eq("R3", "poll opcode", int'(lg_op[1]), 'h0F);
    chk_eq("R3", "poll naddr", int'(lg_na[1]), 1);
    chk_eq("R3", "poll addr", int'(lg_ad[1][7:0]), 'hC0);
    chk_eq("R3", "poll nrx", lg_nrx[1], 1);
    chk_eq("R3", "poll ntx", lg_ntx[1], 0);
    chk_eq("R2", "cache read opcode", int'(lg_op[4]), 'h03);
    chk_eq("R2", "cache read addr", int'(lg_ad[4]), 'h001000);
    chk_eq("R2", "cache read nrx", lg_nrx[4], 8);
    chk_eq("R11", "read byte count", rd_n, 8);
    for (int i = 0; i < 8; i++) chk_eq("R11", "read byte", int'(rdbuf[i]), (16 + i) & 255);
    chk_eq("R11", "status bytes leaked", rd_leak, 0);
  endtask

  task automatic t_read_ecc();
    int code;
    clear_logs(1, 8'h1C);
    run_op(2'd0, 16'h0040, 12'h000, 12'd4, code);
    chk_eq("R7", "corrected, fail bits ignored", code, 3);
    clear_logs(1, 8'h20);
    run_op(2'd0, 16'h0041, 12'h020, 12'd5, code);
    chk_eq("R7", "uncorrectable code", code, 4);
    chk_eq("R8", "cache read still issued", int'(lg_op[lg_n-1]), 'h03);
    chk_eq("R8", "bytes still delivered", rd_n, 5);
    clear_logs(0, 8'h30);
    run_op(2'd0, 16'h0042, 12'h000, 12'd2, code);
    chk_eq("R7", "reserved ecc code", code, 4);
  endtask

  task automatic t_clamp();
    int code;
    clear_logs(0, 8'h00);
    run_op(2'd0, 16'h0005, 12'h800, 12'h060, code);
    chk_eq("R10", "spare area length", lg_nrx[lg_n-1], 64);
    chk_eq("R10", "spare bytes delivered", rd_n, 64);
    clear_logs(0, 8'h00);
    run_op(2'd0, 16'h0005, 12'h830, 12'd100, code);
    chk_eq("R10", "tail length", lg_nrx[lg_n-1], 16);
    clear_logs(0, 8'h00);
    run_op(2'd0, 16'h0005, 12'h840, 12'd5, code);
    chk_eq("R10", "beyond page length", lg_nrx[lg_n-1], 0);
  endtask

  task automatic t_program();
    int code;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'(8'hA0 + i * 3);
    clear_logs(2, 8'h20);
    run_op(2'd1, 16'h0200, 12'h004, 12'd6, code);
    chk_eq("R6", "program ok, ecc ignored", code, 0);
    chk_eq("R4", "program frame count", lg_n, 6);
    chk_eq("R4", "wren opcode", int'(lg_op[0]), 'h06);
    chk_eq("R4", "wren naddr", int'(lg_na[0]), 0);
    chk_eq("R4", "load opcode", int'(lg_op[1]), 'h02);
    chk_eq("R4", "load naddr", int'(lg_na[1]), 2);
    chk_eq("R4", "load addr", int'(lg_ad[1][15:0]), 'h0004);
    chk_eq("R4", "load ntx", lg_ntx[1], 6);
    chk_eq("R4", "exec opcode", int'(lg_op[2]), 'h10);
    chk_eq("R4", "exec addr", int'(lg_ad[2]), 'h000200);
    chk_eq("R4", "poll after exec", int'(lg_op[3]), 'h0F);
    chk_eq("R4", "bytes sent", tx_n, 6);
    for (int i = 0; i < 6; i++) chk_eq("R4", "sent byte", int'(txbuf[i]), int'(wbuf[i]));
    clear_logs(1, 8'h08);
    run_op(2'd1, 16'h0201, 12'h000, 12'd2, code);
    chk_eq("R6", "program fail code", code, 1);
  endtask

  task automatic t_erase();
    int code;
    clear_logs(1, 8'h04);
    run_op(2'd2, 16'h0147, 12'h000, 12'd0, code);
    chk_eq("R6", "erase fail code", code, 2);
    chk_eq("R5", "erase frame count", lg_n, 4);
    chk_eq("R5", "erase wren", int'(lg_op[0]), 'h06);
    chk_eq("R5", "erase opcode", int'(lg_op[1]), 'hD8);
    chk_eq("R5", "erase row aligned", int'(lg_ad[1]), 'h000140);
    clear_logs(0, 8'h08);
    run_op(2'd2, 16'h0080, 12'h000, 12'd0, code);
    chk_eq("R6", "erase ignores program bit", code, 0);
  endtask

  task automatic t_timeout();
    int code;
    clear_logs(20, 8'h00);
    run_op(2'd0, 16'h0011, 12'h000, 12'd4, code);
    chk_eq("R9", "read timeout code", code, 5);
    chk_eq("R9", "no frame after timeout", int'(lg_op[lg_n-1]), 'h0F);
    chk_eq("R9", "no read data", rd_n, 0);
    clear_logs(20, 8'h00);
    run_op(2'd2, 16'h0011, 12'h000, 12'd0, code);
    chk_eq("R9", "erase budget longer", code, 0);
    chk_eq("R9", "erase polls", lg_n, 23);
  endtask

  task automatic t_ignore();
    int code;
    int extra;
    clear_logs(0, 8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk_eq("R1", "op 3 busy", int'(busy), 0);
    chk_eq("R1", "op 3 frames", lg_n, 0);
    clear_logs(3, 8'h00);
    start_op(2'd2, 16'h0300, 12'h000, 12'd0);
    repeat (3) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd0; req_row = 16'h0777;
    @(negedge clk);
    req_valid = 1'b0;
    wait_result(code);
    extra = 0;
    repeat (40) begin
      @(negedge clk);
      if (res_valid || busy) extra++;
    end
    chk_eq("R1", "busy request ignored, frames", lg_n, 6);
    chk_eq("R1", "no extra activity", extra, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) wbuf[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_read_ecc();
    t_clamp();
    t_program();
    t_erase();
    t_timeout();
    t_ignore();
    finish_run();
  end

endmodule